// File: doc/BRIEF.md
# Latency-Driven Issue Interlock Unit

This unit decides, cycle by cycle, whether the next instruction of a single-issue, in-order pipeline may leave the issue stage or must wait. Upstream logic presents one decoded instruction: its class, one destination register tag and two source register tags. The unit answers with `issue` (the instruction leaves this cycle) or `stall` (upstream holds the same instruction for another cycle).

Inside, a small table records each recently issued instruction that writes a register. An entry holds the destination tag, the producer kind and a remaining-latency counter that counts down once per clock. The gap a consumer needs is looked up from a table indexed by the producer kind and the role in which the consumer reads the register. The roles are FP operand, store data, integer operand or address, and branch operand. The unit stalls for the largest gap still outstanding over all sources. Forwarding paths, execution, caches and branch outcomes are not part of this block.

A two-state machine sequences the stall. In `S_READY` the unit issues when no gap is outstanding. If one cycle is missing it stalls and stays in `S_READY`. If more are missing it stalls and takes the `enter_wait` transition to `S_WAIT`, loading a down-counter with the remaining stall cycles. `S_WAIT` holds `stall` high and counts down. When the counter reaches its last cycle it takes the `wait_done` transition back to `S_READY`, where the instruction issues.

Top module: `ilk_issue_ctl`

## Requirements
- R1: An FP operation reading the result of an FP operation needs 3 cycles between the two issues, so an adjacent consumer sees 3 stall cycles.
- R2: A store whose data register is written by an FP operation needs 2 intervening cycles.
- R3: An FP operation reading a load result needs 1 intervening cycle.
- R4: A store whose data register is written by a load needs no intervening cycle.
- R5: A branch reading a register written by an integer operation needs 1 intervening cycle, on either branch source.
- R6: Every cycle between producer and consumer counts toward the gap, whether it carries an independent instruction or no valid instruction, and reduces the stall one for one. A register with no pending producer costs no stall.
- R7: When several sources are pending, the stall is the largest of the per-source stalls.
- R8: The address register of a load or store is checked as an integer operand, with integer-to-integer latency 0 by default.
- R9: A register tag is 6 bits: bit 5 set selects the FP file, clear selects the integer file, and bits 4:0 hold the index. Tag 0 (integer register 0) is never a dependency, as source or destination.
- R10: When a later instruction writes a register that has a pending entry, only the later producer governs consumers of that register.
- R11: Class codes are 0 FP operation (dst, src_a, src_b), 1 load (dst, src_a address), 2 store (src_a address, src_b data), 3 integer operation (dst, src_a), 4 branch (src_a, src_b). Codes 5 to 7 use no operands. Operands a class does not use cause no stall.
- R12: After reset, and in every cycle with `in_valid` low, `issue` and `stall` are both low. With `in_valid` high exactly one of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_class | input | 3 | Instruction class code (R11) |
| in_dst | input | 6 | Destination register tag (R9) |
| in_src_a | input | 6 | First source register tag |
| in_src_b | input | 6 | Second source register tag |
| issue | output | 1 | The presented instruction issues this cycle |
| stall | output | 1 | The presented instruction must be held |

## Verification
The assertions assume that upstream obeys the stall: while `stall` is high, the same instruction stays presented with `in_valid` high into the next cycle. The `S_WAIT` properties depend on this, because the down-counter was loaded from the held instruction's sources. They also assume that a register is given the same file bit by every class that names it. The bench's driver keeps each instruction on the inputs, unchanged, until it observes `issue`. It only withdraws `in_valid` at the next falling edge, and its register tags always follow the file each class expects.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    typedef enum logic [2:0] {
        CL_FPALU  = 3'd0,
        CL_LOADD  = 3'd1,
        CL_STORED = 3'd2,
        CL_INTALU = 3'd3,
        CL_BRANCH = 3'd4
    } iclass_e;

    // kind of instruction that left a pending result
    typedef enum logic [1:0] {
        PR_FP  = 2'd0,
        PR_LD  = 2'd1,
        PR_INT = 2'd2
    } prod_e;

    // role in which a source operand is consumed
    typedef enum logic [1:0] {
        RL_FP     = 2'd0,
        RL_STDATA = 2'd1,
        RL_INT    = 2'd2,
        RL_BR     = 2'd3
    } role_e;

    typedef struct packed {
        logic  dst_en;
        prod_e prod;
        logic  a_en;
        role_e a_role;
        logic  b_en;
        role_e b_role;
    } ops_t;

endpackage

// File: rtl/ilk_decode.sv
module ilk_decode
    import ilk_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic [2:0]       cls,
    input  logic [TAG_W-1:0] dst,
    input  logic [TAG_W-1:0] src_a,
    input  logic [TAG_W-1:0] src_b,
    output ops_t             ops
);

    localparam logic [TAG_W-1:0] ZERO_TAG = '0;

    ops_t raw;

    always_comb begin
        raw        = '0;
        raw.prod   = PR_FP;
        raw.a_role = RL_FP;
        raw.b_role = RL_FP;
        unique case (iclass_e'(cls))
            CL_FPALU: begin
                raw.dst_en = 1'b1;
                raw.prod   = PR_FP;
                raw.a_en   = 1'b1;
                raw.b_en   = 1'b1;
            end
            CL_LOADD: begin
                raw.dst_en = 1'b1;
                raw.prod   = PR_LD;
                raw.a_en   = 1'b1;
                raw.a_role = RL_INT;
            end
            CL_STORED: begin
                raw.a_en   = 1'b1;
                raw.a_role = RL_INT;
                raw.b_en   = 1'b1;
                raw.b_role = RL_STDATA;
            end
            CL_INTALU: begin
                raw.dst_en = 1'b1;
                raw.prod   = PR_INT;
                raw.a_en   = 1'b1;
                raw.a_role = RL_INT;
            end
            CL_BRANCH: begin
                raw.a_en   = 1'b1;
                raw.a_role = RL_BR;
                raw.b_en   = 1'b1;
                raw.b_role = RL_BR;
            end
            default: ;
        endcase
    end

    // integer register 0 never carries a dependency
    always_comb begin
        ops        = raw;
        ops.dst_en = raw.dst_en && (dst != ZERO_TAG);
        ops.a_en   = raw.a_en && (src_a != ZERO_TAG);
        ops.b_en   = raw.b_en && (src_b != ZERO_TAG);
    end

endmodule

// File: rtl/ilk_score.sv
module ilk_score
    import ilk_pkg::*;
#(
    parameter int TAG_W      = 6,
    parameter int DEPTH      = 4,
    parameter int LAT_W      = 3,
    parameter int LAT_FP_FP  = 3,
    parameter int LAT_FP_ST  = 2,
    parameter int LAT_LD_FP  = 1,
    parameter int LAT_LD_ST  = 0,
    parameter int LAT_INT_BR = 1,
    parameter int LAT_INT_OP = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ops_t             ops,
    input  logic [TAG_W-1:0] in_dst,
    input  logic [TAG_W-1:0] in_src_a,
    input  logic [TAG_W-1:0] in_src_b,
    input  logic             alloc,
    output logic [LAT_W-1:0] need
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    function automatic int lat_of(prod_e p, role_e r);
        unique case (p)
            PR_FP:   return (r == RL_FP) ? LAT_FP_FP : (r == RL_STDATA) ? LAT_FP_ST : 0;
            PR_LD:   return (r == RL_FP) ? LAT_LD_FP : (r == RL_STDATA) ? LAT_LD_ST : 0;
            PR_INT:  return (r == RL_BR) ? LAT_INT_BR : (r == RL_INT) ? LAT_INT_OP : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int lmax_of(prod_e p);
        int m;
        m = lat_of(p, RL_FP);
        if (lat_of(p, RL_STDATA) > m) m = lat_of(p, RL_STDATA);
        if (lat_of(p, RL_INT) > m)    m = lat_of(p, RL_INT);
        if (lat_of(p, RL_BR) > m)     m = lat_of(p, RL_BR);
        return m;
    endfunction

    // cycles still missing for a consumer in role r of an entry
    function automatic logic [LAT_W-1:0] gap_need(logic [LAT_W-1:0] rem, prod_e p, role_e r);
        int slack;
        slack = lmax_of(p) - lat_of(p, r);
        if (int'(rem) > slack) return LAT_W'(int'(rem) - slack);
        return '0;
    endfunction

    logic             ent_vld  [DEPTH];
    logic [TAG_W-1:0] ent_tag  [DEPTH];
    prod_e            ent_prod [DEPTH];
    logic [LAT_W-1:0] ent_rem  [DEPTH];

    logic [DEPTH-1:0] hit_a, hit_b, hit_d, reuse, live_zero;
    logic [LAT_W-1:0] need_a [DEPTH];
    logic [LAT_W-1:0] need_b [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign hit_a[i]     = ent_vld[i] && ops.a_en && (ent_tag[i] == in_src_a);
        assign hit_b[i]     = ent_vld[i] && ops.b_en && (ent_tag[i] == in_src_b);
        assign hit_d[i]     = ent_vld[i] && (ent_tag[i] == in_dst);
        assign reuse[i]     = !ent_vld[i] || (ent_rem[i] == LAT_W'(1));
        assign live_zero[i] = ent_vld[i] && (ent_rem[i] == '0);
        assign need_a[i]    = hit_a[i] ? gap_need(ent_rem[i], ent_prod[i], ops.a_role) : '0;
        assign need_b[i]    = hit_b[i] ? gap_need(ent_rem[i], ent_prod[i], ops.b_role) : '0;
    end

    always_comb begin
        need = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (need_a[i] > need) need = need_a[i];
            if (need_b[i] > need) need = need_b[i];
        end
    end

    // slot choice: a superseded entry first, otherwise the first reusable one
    logic [IDX_W-1:0] slot;
    logic             slot_ok;
    logic             do_alloc;

    assign do_alloc = alloc && ops.dst_en;

    always_comb begin
        slot    = '0;
        slot_ok = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_d[i] && !slot_ok) begin
                slot    = IDX_W'(i);
                slot_ok = 1'b1;
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (reuse[i] && !slot_ok) begin
                slot    = IDX_W'(i);
                slot_ok = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_vld[i]  <= 1'b0;
                ent_tag[i]  <= '0;
                ent_prod[i] <= PR_FP;
                ent_rem[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (do_alloc && slot == IDX_W'(i)) begin
                    ent_vld[i]  <= (lmax_of(ops.prod) > 0);
                    ent_tag[i]  <= in_dst;
                    ent_prod[i] <= ops.prod;
                    ent_rem[i]  <= LAT_W'(lmax_of(ops.prod));
                end else if (ent_vld[i]) begin
                    if (ent_rem[i] <= LAT_W'(1)) begin
                        ent_vld[i] <= 1'b0;
                        ent_rem[i] <= '0;
                    end else begin
                        ent_rem[i] <= ent_rem[i] - LAT_W'(1);
                    end
                end
            end
        end
    end

    // R10: a register has at most one governing entry
    p_single_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_a) && $onehot0(hit_b));

    // R10: a writer always finds a slot
    p_slot_found_r10: assert property (@(posedge clk) disable iff (!rst_n)
        do_alloc |-> slot_ok);

    // R6: an entry is retired no later than the cycle its count runs out
    p_live_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        live_zero == '0);

endmodule

// File: rtl/ilk_seq.sv
module ilk_seq #(
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [LAT_W-1:0] need,
    output logic             issue,
    output logic             stall
);

    typedef enum logic {
        S_READY = 1'b0,
        S_WAIT  = 1'b1
    } seq_e;

    seq_e             st, st_n;
    logic [LAT_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= S_READY;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            S_READY: begin
                if (in_valid && need > LAT_W'(1)) begin   // enter_wait
                    st_n  = S_WAIT;
                    cnt_n = need - LAT_W'(1);
                end
            end
            S_WAIT: begin
                cnt_n = cnt - LAT_W'(1);
                if (cnt == LAT_W'(1)) st_n = S_READY;   // wait_done
            end
            default: st_n = S_READY;
        endcase
    end

    always_comb begin
        issue = 1'b0;
        stall = 1'b0;
        unique case (st)
            S_READY: begin
                stall = in_valid && (need != '0);
                issue = in_valid && (need == '0);
            end
            S_WAIT:  stall = 1'b1;
            default: ;
        endcase
    end

    // R6: on wait_done the table must show the gap closed
    p_wait_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_READY && $past(st == S_WAIT) && in_valid) |-> (need == '0));

    // R12: waiting only happens with an instruction held at the input
    p_hold_input_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT) |-> in_valid);

    // R1: the wait counter is never idle in S_WAIT
    p_wait_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT) |-> (cnt != '0));

endmodule

// File: rtl/ilk_issue_ctl.sv
module ilk_issue_ctl #(
    parameter int REG_IDX_W  = 5,
    parameter int DEPTH      = 4,
    parameter int LAT_W      = 3,
    parameter int LAT_FP_FP  = 3,
    parameter int LAT_FP_ST  = 2,
    parameter int LAT_LD_FP  = 1,
    parameter int LAT_LD_ST  = 0,
    parameter int LAT_INT_BR = 1,
    parameter int LAT_INT_OP = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [2:0]           in_class,
    input  logic [REG_IDX_W:0]   in_dst,
    input  logic [REG_IDX_W:0]   in_src_a,
    input  logic [REG_IDX_W:0]   in_src_b,
    output logic                 issue,
    output logic                 stall
);

    import ilk_pkg::*;

    localparam int TAG_W = REG_IDX_W + 1;

    ops_t             ops;
    logic [LAT_W-1:0] need;

    ilk_decode #(.TAG_W(TAG_W)) u_decode (
        .cls   (in_class),
        .dst   (in_dst),
        .src_a (in_src_a),
        .src_b (in_src_b),
        .ops   (ops)
    );

    ilk_score #(
        .TAG_W      (TAG_W),
        .DEPTH      (DEPTH),
        .LAT_W      (LAT_W),
        .LAT_FP_FP  (LAT_FP_FP),
        .LAT_FP_ST  (LAT_FP_ST),
        .LAT_LD_FP  (LAT_LD_FP),
        .LAT_LD_ST  (LAT_LD_ST),
        .LAT_INT_BR (LAT_INT_BR),
        .LAT_INT_OP (LAT_INT_OP)
    ) u_score (
        .clk      (clk),
        .rst_n    (rst_n),
        .ops      (ops),
        .in_dst   (in_dst),
        .in_src_a (in_src_a),
        .in_src_b (in_src_b),
        .alloc    (issue),
        .need     (need)
    );

    ilk_seq #(.LAT_W(LAT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .need     (need),
        .issue    (issue),
        .stall    (stall)
    );

    // R12: exactly one answer per valid cycle, none otherwise
    p_one_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid ? (issue ^ stall) : !(issue || stall));

    // R9: a branch on integer register 0 alone never waits
    p_zero_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 3'd4 && in_src_a == '0 && in_src_b == '0) |-> !stall);

endmodule

// File: tb/ilk_issue_ctl_tb_top.sv
module ilk_issue_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_class = '0;
    logic [5:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic       issue, stall;

    always #5 clk = ~clk;

    ilk_issue_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .issue(issue), .stall(stall)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    total = 0, bad = 0;
    int    expq[$];
    string nq[$];

    // bench model of pending producers, indexed by tag
    bit pv [64];
    int pcls [64];
    int pcyc [64];

    function automatic logic [5:0] fr(int k); return {1'b1, 5'(k)}; endfunction
    function automatic logic [5:0] ir(int k); return {1'b0, 5'(k)}; endfunction

    // role codes: 0 fp op, 1 store data, 2 int op/address, 3 branch, -1 unused
    function automatic int role_of(int cls, int k);
        case (cls)
            0: return 0;
            1: return (k == 0) ? 2 : -1;
            2: return (k == 0) ? 2 : 1;
            3: return (k == 0) ? 2 : -1;
            4: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic int blat(int p, int role);
        if (p == 0 && role == 0) return 3;
        if (p == 0 && role == 1) return 2;
        if (p == 1 && role == 0) return 1;
        if (p == 3 && role == 3) return 1;
        return 0;
    endfunction

    task automatic send(input string rq, input int cls, input logic [5:0] d,
                        input logic [5:0] a, input logic [5:0] b);
        int c0, earliest, e, role;
        logic [5:0] s;
        c0 = cyc;
        earliest = c0;
        for (int k = 0; k < 2; k++) begin
            s = (k == 0) ? a : b;
            role = role_of(cls, k);
            if (role >= 0 && s != 6'd0 && pv[s]) begin
                e = pcyc[s] + blat(pcls[s], role) + 1;
                if (e > earliest) earliest = e;
            end
        end
        expq.push_back(earliest - c0);
        nq.push_back(rq);
        in_valid = 1'b1; in_class = 3'(cls); in_dst = d; in_src_a = a; in_src_b = b;
        #3;
        while (!issue) begin
            @(negedge clk);
            #3;
        end
        if ((cls == 0 || cls == 1 || cls == 3) && d != 6'd0) begin
            pv[d] = 1'b1; pcls[d] = cls; pcyc[d] = cyc;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        #2;
        total++;
        if (issue || stall) begin
            bad++;
            $display("FAIL R12 idle cycle: issue=%0b stall=%0b expected 0 0", issue, stall);
        end
        @(negedge clk);
        if (n > 1) repeat (n - 1) @(negedge clk);
    endtask

    // monitor: counts stall cycles of each instruction, compares at issue
    initial begin
        int run, exp;
        string nm;
        run = 0;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && in_valid) begin
                if (stall) run++;
                if (issue) begin
                    total++;
                    if (expq.size() == 0) begin
                        bad++;
                        $display("FAIL R12 unexpected issue: stalls=%0d expected none", run);
                    end else begin
                        exp = expq.pop_front();
                        nm = nq.pop_front();
                        if (run != exp) begin
                            bad++;
                            $display("FAIL %s stalls=%0d expected=%0d", nm, run, exp);
                        end
                    end
                    run = 0;
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired: issued=%0d expected all", total);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        total++;
        if (issue || stall) begin
            bad++;
            $display("FAIL R12 reset state: issue=%0b stall=%0b expected 0 0", issue, stall);
        end
        @(negedge clk);

        send("R1",  0, fr(2),  fr(0),  fr(1));
        send("R1",  0, fr(4),  fr(2),  fr(3));
        send("R2",  0, fr(6),  fr(0),  fr(1));
        send("R2",  2, 6'd0,   ir(1),  fr(6));
        send("R3",  1, fr(8),  ir(1),  6'd0);
        send("R3",  0, fr(10), fr(8),  fr(0));
        send("R4",  1, fr(12), ir(1),  6'd0);
        send("R4",  2, 6'd0,   ir(1),  fr(12));
        send("R5",  3, ir(3),  ir(1),  6'd0);
        send("R5",  4, 6'd0,   ir(3),  ir(4));
        send("R5",  3, ir(12), ir(1),  6'd0);
        send("R5",  4, 6'd0,   ir(1),  ir(12));
        send("R8",  3, ir(5),  ir(1),  6'd0);
        send("R8",  2, 6'd0,   ir(5),  fr(0));
        send("R8",  3, ir(6),  ir(1),  6'd0);
        send("R8",  1, fr(14), ir(6),  6'd0);
        send("R6",  0, fr(16), fr(0),  fr(1));
        send("R6",  3, ir(7),  ir(1),  6'd0);
        send("R6",  0, fr(18), fr(16), fr(0));
        send("R6",  0, fr(20), fr(0),  fr(1));
        idle(2);
        send("R6",  0, fr(22), fr(20), fr(0));
        send("R7",  1, fr(24), ir(1),  6'd0);
        send("R7",  0, fr(26), fr(0),  fr(1));
        send("R7",  0, fr(28), fr(24), fr(26));
        send("R7",  0, fr(5),  fr(0),  fr(1));
        send("R7",  3, ir(9),  ir(1),  6'd0);
        send("R7",  2, 6'd0,   ir(9),  fr(5));
        send("R9",  3, 6'd0,   ir(1),  6'd0);
        send("R9",  4, 6'd0,   6'd0,   6'd0);
        send("R10", 0, fr(7),  fr(0),  fr(1));
        send("R10", 1, fr(7),  ir(1),  6'd0);
        send("R10", 0, fr(9),  fr(7),  fr(0));
        send("R11", 0, fr(11), fr(0),  fr(1));
        send("R11", 1, fr(13), ir(1),  fr(11));
        send("R11", 0, fr(15), fr(0),  fr(1));
        send("R11", 5, fr(17), fr(15), fr(15));
        idle(3);

        total++;
        if (expq.size() != 0) begin
            bad++;
            $display("FAIL R12 pending results: left=%0d expected 0", expq.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule